// File: doc/BRIEF.md
# Three-lane 18-bit pixel serializer with clock lane

This block takes one pixel per pixel-clock cycle and turns it into four serial bit streams for a flat-panel link. A pixel is 6-bit red, 6-bit green and 6-bit blue, with MSB at bit 5, plus horizontal sync, vertical sync and a data-enable strobe. The 21 bits are split across three 7-bit data lanes with a fixed lane assignment that mixes colours. A fourth lane carries the clock pattern that the receiver uses to frame each group of seven bits. External differential drivers turn the single-ended outputs into pairs.

The pixel clock (50 to 67 MHz in use) and a bit clock running at exactly seven times its rate are both inputs. The pixel word is captured on the pixel clock and a toggle flag flips with each capture. The bit-clock domain synchronizes that flag through two flops. Each detected flip produces a single-cycle load pulse that copies the stable word into the shift stage and restarts the bit phase at zero. An enable input, sampled on the bit clock, forces every serial output low while it is deasserted.

Top module: `rgb_lane_serializer`

## Requirements
- R1: Data lane 0 sends, from first to last bit of a pixel period, green[0], red[5], red[4], red[3], red[2], red[1], red[0].
- R2: Data lane 1 sends, first to last, blue[1], blue[0], green[5], green[4], green[3], green[2], green[1].
- R3: Data lane 2 sends, first to last, data-enable, vsync, hsync, blue[5], blue[4], blue[3], blue[2].
- R4: The clock lane sends 1,1,0,0,0,1,1 (first to last) in every pixel period, aligned to the first bit of the data lanes.
- R5: With a continuous pixel clock, each lane emits exactly seven bits per pixel with no gap and no repeated bit between pixels.
- R6: While the enable input is low at a bit-clock edge, all four serial outputs are low after that edge.
- R7: While reset is asserted, and after reset until the first pixel word has been loaded, all four serial outputs are low.
- R8: Sync and data-enable levels are sent exactly as presented, with either polarity and no qualification: a pixel with data-enable low still sends its colour bits unchanged.
- R9: When a pixel-clock rising edge falls between two bit-clock edges, the first bit of the pixel captured there appears on the outputs right after the fourth bit-clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock, seven times the pixel clock |
| pix_clk | input | 1 | Pixel clock, one pixel per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| tx_en | input | 1 | Output enable, bit-clock domain; low forces all serial outputs low |
| red | input | 6 | Red intensity, bit 5 is the MSB |
| green | input | 6 | Green intensity, bit 5 is the MSB |
| blue | input | 6 | Blue intensity, bit 5 is the MSB |
| hsync | input | 1 | Horizontal sync, either polarity |
| vsync | input | 1 | Vertical sync, either polarity |
| de | input | 1 | Data-enable, high marks a displayable pixel |
| lane0_o | output | 1 | Serial data lane 0 |
| lane1_o | output | 1 | Serial data lane 1 |
| lane2_o | output | 1 | Serial data lane 2 |
| clk_lane_o | output | 1 | Serial clock-pattern lane |

## Verification
The assertions check on every bit-clock cycle that the bit phase wraps after seven counts or restarts on a load. They also check that a load is a single-cycle pulse, and that the outputs stay low while disabled or before the first load. Lane bit order, colour-to-lane mapping, the clock pattern's alignment to word boundaries and the four-edge capture latency can only be shown by the bench's reference stream. That stream is tested with zero, walking-one, all-ones and random pixels, an enable gap, a single-cycle enable drop and a reset taken while enabled.

// File: rtl/lvds_pack_pkg.sv
package lvds_pack_pkg;

  localparam int COLOR_W    = 6;
  localparam int LANE_BITS  = 7;
  localparam int DATA_LANES = 3;
  localparam int ALL_LANES  = DATA_LANES + 1;
  localparam int PHASE_W    = $clog2(LANE_BITS);

  typedef logic [LANE_BITS-1:0] lane_word_t;

  typedef struct packed {
    logic [COLOR_W-1:0] r;
    logic [COLOR_W-1:0] g;
    logic [COLOR_W-1:0] b;
    logic               hs;
    logic               vs;
    logic               de;
  } pixel_t;

  // MSB of each lane word goes out first.
  localparam lane_word_t CLK_PATTERN = 7'b1100011;

  function automatic lane_word_t pack_lane(input pixel_t p, input int idx);
    lane_word_t w;
    case (idx)
      0:       w = {p.g[0], p.r[5:0]};
      1:       w = {p.b[1:0], p.g[5:1]};
      default: w = {p.de, p.vs, p.hs, p.b[5:2]};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/pixel_capture.sv
module pixel_capture
  import lvds_pack_pkg::*;
(
  input  logic                              pix_clk,
  input  logic                              rst_n,
  input  pixel_t                            pix_in,
  output logic [DATA_LANES*LANE_BITS-1:0]   words_o,
  output logic                              flag_o
);

  logic [DATA_LANES*LANE_BITS-1:0] words_d, words_q;
  logic                            flag_d, flag_q;
  logic                            cap_en;

  assign cap_en = 1'b1;

  always_comb begin
    words_d = words_q;
    flag_d  = flag_q;
    if (cap_en) begin
      for (int i = 0; i < DATA_LANES; i++) begin
        words_d[i*LANE_BITS +: LANE_BITS] = pack_lane(pix_in, i);
      end
      flag_d = ~flag_q;
    end
  end

  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      words_q <= words_d;
      flag_q  <= flag_d;
    end
  end

  assign words_o = words_q;
  assign flag_o  = flag_q;

endmodule

// File: rtl/word_handoff.sv
module word_handoff
  import lvds_pack_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                            bit_clk,
  input  logic                            rst_n,
  input  logic                            flag_in,
  input  logic [DATA_LANES*LANE_BITS-1:0] words_in,
  output logic                            load_o,
  output logic [DATA_LANES*LANE_BITS-1:0] hold_o
);

  logic [SYNC_STAGES:0]            sync_q, sync_d;
  logic [DATA_LANES*LANE_BITS-1:0] hold_q, hold_d;
  logic                            load;

  // A flip of the synchronized flag means a new, settled word.
  assign load = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-1:0], flag_in};
    hold_d = load ? words_in : hold_q;
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hold_q <= '0;
    end else begin
      sync_q <= sync_d;
      hold_q <= hold_d;
    end
  end

  assign load_o = load;
  assign hold_o = hold_q;

  a_r9_load_single: assert property (@(posedge bit_clk) disable iff (!rst_n)
    load |=> !load);

endmodule

// File: rtl/lane_shifter.sv
module lane_shifter
  import lvds_pack_pkg::*;
(
  input  logic                            bit_clk,
  input  logic                            rst_n,
  input  logic                            en,
  input  logic                            load,
  input  logic [DATA_LANES*LANE_BITS-1:0] hold,
  output logic [ALL_LANES-1:0]            ser_o
);

  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(LANE_BITS - 1);

  logic [PHASE_W-1:0]   phase_q, phase_d;
  logic                 primed_q, primed_d;
  logic [ALL_LANES-1:0] out_q, out_d;
  logic [PHASE_W-1:0]   bit_idx;
  lane_word_t           lane_word [ALL_LANES];

  assign bit_idx = LAST - phase_q;

  generate
    for (genvar L = 0; L < ALL_LANES; L++) begin : g_lane
      if (L < DATA_LANES) begin : g_data
        assign lane_word[L] = hold[L*LANE_BITS +: LANE_BITS];
      end else begin : g_clk
        assign lane_word[L] = CLK_PATTERN;
      end
      assign out_d[L] = en & primed_q & lane_word[L][bit_idx];
    end
  endgenerate

  always_comb begin
    primed_d = primed_q | load;
    if (load)                phase_d = '0;
    else if (phase_q == LAST) phase_d = '0;
    else                     phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      primed_q <= 1'b0;
      out_q    <= '0;
    end else begin
      phase_q  <= phase_d;
      primed_q <= primed_d;
      out_q    <= out_d;
    end
  end

  assign ser_o = out_q;

  a_r5_phase_wrap: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!load && phase_q == LAST) |=> phase_q == '0);

  a_r5_load_restart: assert property (@(posedge bit_clk) disable iff (!rst_n)
    load |=> phase_q == '0);

  a_r6_disabled_low: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !en |=> ser_o == '0);

  a_r7_unprimed_low: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !primed_q |=> ser_o == '0);

endmodule

// File: rtl/rgb_lane_serializer.sv
module rgb_lane_serializer
  import lvds_pack_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic               bit_clk,
  input  logic               pix_clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic [COLOR_W-1:0] red,
  input  logic [COLOR_W-1:0] green,
  input  logic [COLOR_W-1:0] blue,
  input  logic               hsync,
  input  logic               vsync,
  input  logic               de,
  output logic               lane0_o,
  output logic               lane1_o,
  output logic               lane2_o,
  output logic               clk_lane_o
);

  logic                            px_rst_n, bc_rst_n;
  pixel_t                          pix;
  logic [DATA_LANES*LANE_BITS-1:0] px_words, hold;
  logic                            px_flag, load;
  logic [ALL_LANES-1:0]            ser;

  assign pix = '{r: red, g: green, b: blue, hs: hsync, vs: vsync, de: de};

  rst_release_sync #(.STAGES(RST_STAGES)) i_px_rst (
    .clk(pix_clk), .arst_n(rst_n), .srst_n(px_rst_n));

  rst_release_sync #(.STAGES(RST_STAGES)) i_bc_rst (
    .clk(bit_clk), .arst_n(rst_n), .srst_n(bc_rst_n));

  pixel_capture i_cap (
    .pix_clk(pix_clk), .rst_n(px_rst_n), .pix_in(pix),
    .words_o(px_words), .flag_o(px_flag));

  word_handoff #(.SYNC_STAGES(SYNC_STAGES)) i_handoff (
    .bit_clk(bit_clk), .rst_n(bc_rst_n), .flag_in(px_flag),
    .words_in(px_words), .load_o(load), .hold_o(hold));

  lane_shifter i_shift (
    .bit_clk(bit_clk), .rst_n(bc_rst_n), .en(tx_en), .load(load),
    .hold(hold), .ser_o(ser));

  assign lane0_o    = ser[0];
  assign lane1_o    = ser[1];
  assign lane2_o    = ser[2];
  assign clk_lane_o = ser[3];

endmodule

// File: tb/test_rgb_lane_serializer.sv
`timescale 1ns/1ps
module test_rgb_lane_serializer;

  logic bit_clk, pix_clk, rst_n, tx_en;
  logic [5:0] red, green, blue;
  logic hsync, vsync, de;
  logic lane0_o, lane1_o, lane2_o, clk_lane_o;

  rgb_lane_serializer i_rgb_lane_serializer (
    .bit_clk(bit_clk), .pix_clk(pix_clk), .rst_n(rst_n), .tx_en(tx_en),
    .red(red), .green(green), .blue(blue), .hsync(hsync), .vsync(vsync),
    .de(de), .lane0_o(lane0_o), .lane1_o(lane1_o), .lane2_o(lane2_o),
    .clk_lane_o(clk_lane_o));

  typedef struct {
    int         start;
    logic [6:0] w0, w1, w2;
  } exp_word_t;

  exp_word_t q[$];
  int total = 0, bad = 0, cyc = 0, pix_n = 0, px_seen = 0;
  logic en_e = 1'b0;
  bit done = 0;

  // 50 MHz bit clock; pixel clock = bit clock / 7, rising 5 ns after a bit edge
  initial begin bit_clk = 1'b0; forever #10 bit_clk = ~bit_clk; end
  initial begin pix_clk = 1'b0; #15; forever begin pix_clk = 1'b1; #70; pix_clk = 1'b0; #70; end end

  always @(posedge bit_clk) begin cyc = cyc + 1; en_e = tx_en; end

  // Model of which pixel edges capture: third pixel edge after reset release onward
  always @(posedge pix_clk) begin
    exp_word_t e;
    if (!rst_n) px_seen = 0;
    else begin
      px_seen = px_seen + 1;
      if (px_seen >= 3) begin
        e.start = cyc + 4;                          // R9: four bit edges later
        e.w0 = {green[0], red};                     // R1
        e.w1 = {blue[1:0], green[5:1]};             // R2
        e.w2 = {de, vsync, hsync, blue[5:2]};       // R3, R8
        q.push_back(e);
      end
    end
  end

  // Pixel stimulus: zeros, walking one, all ones, then random (R8: any sync/de level)
  always @(negedge pix_clk) begin
    logic [20:0] v;
    pix_n = pix_n + 1;
    if (pix_n < 10)       v = '0;
    else if (pix_n < 31)  v = 21'(1) << (pix_n - 10);
    else if (pix_n < 35)  v = '1;
    else                  v = 21'($urandom);
    {red, green, blue, hsync, vsync, de} = v;
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  always @(negedge bit_clk) begin
    logic [3:0] e;
    int p;
    string t0, t1, t2, tc;
    if (!done) begin
      e = '0;
      t0 = "R7"; t1 = "R7"; t2 = "R7"; tc = "R7";
      if (!rst_n) q.delete();
      else begin
        while (q.size() > 1 && q[1].start <= cyc) void'(q.pop_front());
        if (q.size() > 0 && q[0].start <= cyc) begin
          p = cyc - q[0].start;
          if (p > 6) begin
            total++; bad++;
            $display("FAIL R5 cycle %0d: actual=gap of %0d expected=at most 6", cyc, p);
          end else if (!en_e) begin
            t0 = "R6"; t1 = "R6"; t2 = "R6"; tc = "R6";
          end else begin
            e = {1'b1 & (7'b1100011 >> (6 - p)),
                 q[0].w2[6-p], q[0].w1[6-p], q[0].w0[6-p]};
            t0 = "R1 R9"; t1 = "R2 R9"; t2 = "R3 R8 R9"; tc = "R4 R5";
          end
        end
      end
      chk(lane0_o, e[0], t0);
      chk(lane1_o, e[1], t1);
      chk(lane2_o, e[2], t2);
      chk(clk_lane_o, e[3], tc);
    end
  end

  initial begin
    rst_n = 1'b0; tx_en = 1'b0;
    for (int c = 1; c <= 1400; c++) begin
      @(posedge bit_clk); #2;
      rst_n = !(c < 3 || (c >= 700 && c < 704));               // R7: reset while enabled
      tx_en = (c >= 60 && c < 400) || (c >= 430 && c != 900);  // R6: gap and 1-cycle drop
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule